// File: doc/BRIEF.md
# Two-Processor Store Buffer Subsystem with Global Lock

This block puts a small first-in first-out store buffer between each of two processors and a single shared word-addressed memory, and adds one global lock register that grants exclusive access. Each processor issues one command per cycle: a buffered write, a read, a memory fence, a lock acquire, a lock release, or a no-op barrier. The block answers each command in the same cycle with accept or stall. A stalled command is held by the processor and offered again in later cycles.

Writes never go straight to memory. They sit in the issuing processor's buffer until a drain request for that processor is granted. A granted drain commits the oldest buffered entry. A read first looks in the processor's own buffer and takes the youngest entry with the same address. If there is none, it takes the shared memory word. This gives total-store-order behaviour: a processor sees its own writes at once, and other processors see them only after they drain. The lock limits which buffers may drain, and fence, acquire and release wait until the issuing buffer is empty. Together these let software build atomic sections.

Command codes on the 3-bit operation field: 0 no-op barrier, 1 write, 2 read, 3 fence, 4 lock acquire, 5 lock release. Codes 6 and 7 are treated as no-op barriers.

Top module: `tso_sbuf_lock`

## Requirements
- R1: A lock acquire (code 4) is accepted in the cycle it is offered only if the issuing buffer is empty and no processor holds the lock. The lock is then held by the issuer from the next cycle. When both processors qualify in the same cycle, processor 0 wins and processor 1 stalls.
- R2: A lock release (code 5) is accepted only if the issuing buffer is empty and the issuer currently holds the lock. The lock is free from the next cycle. A release from a non-owner stalls.
- R3: A fence (code 3) is accepted only when the issuing buffer is empty. A no-op barrier (code 0, 6 or 7) is accepted at once and has no effect.
- R4: A write (code 1) is accepted when the issuing buffer holds fewer than DEPTH entries, and it appends {address, data} at the tail. A write to a full buffer stalls, even in a cycle where that buffer drains.
- R5: A drain request for processor p is granted only when p's buffer is non-empty and the lock is free or held by p. At most one grant is given per cycle. A granted drain writes p's oldest entry to memory at that clock edge.
- R6: A read (code 2) is always accepted. One cycle later rd_valid of that processor is high with rd_data equal to the youngest entry in its own buffer with a matching address, or else the memory word. The value is taken from the state before the accepting edge.
- R7: Entries of one buffer reach memory in the order they were written. A later write to the same address overwrites an earlier one in program order.
- R8: When both processors are eligible to drain in the same cycle, the grant goes to the processor favoured by a round-robin pointer. The pointer starts at processor 0 and moves to the other processor after every grant.
- R9: Reset (active low, synchronous) empties both buffers, frees the lock, resets the round-robin pointer and sets every memory word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | NPROC | Command offered, one bit per processor |
| cmd_op | input | NPROC*3 | Operation code per processor |
| cmd_addr | input | NPROC*AW | Address per processor |
| cmd_wdata | input | NPROC*DW | Write data per processor |
| cmd_accept | output | NPROC | Command completes this cycle (low means stall) |
| rd_valid | output | NPROC | Read result present, one cycle after accept |
| rd_data | output | NPROC*DW | Read result per processor |
| drain_req | input | NPROC | Request to commit the buffer head, per processor |
| drain_grant | output | NPROC | Drain granted this cycle (one-hot or zero) |

## Verification
cmd_accept and drain_grant are combinational, so they are due in the same cycle as the stimulus. The bench drives at the falling edge and samples them one nanosecond later, before the rising edge that acts on them. Read data is registered and is due at the falling edge that follows the accepting rising edge. The bench builds the expected value at accept time from its own model state before that edge and queues it, and a monitor pops the queue whenever rd_valid is high. Buffer, lock and memory changes take effect at the accepting edge. The model applies them in the same step, so the next cycle's expected stalls and grants already reflect them.

// File: rtl/sbl_pkg.sv
// Shared definitions for the store-buffer / lock subsystem.
// Assumes a 3-bit operation field on every processor port.
package sbl_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_FENCE = 3'd3,
        OP_ACQ   = 3'd4,
        OP_REL   = 3'd5
    } sbl_op_e;
endpackage

// File: rtl/sbl_store_fifo.sv
// Per-processor store buffer: a circular FIFO of {address, data} entries.
// Provides the head entry for draining and a youngest-match lookup for
// read forwarding. Assumes the caller never pushes when full nor pops
// when empty; the lookup reflects state before the current edge.
module sbl_store_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic [DW-1:0] look_data,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] ent_addr [DEPTH];
    logic [DW-1:0] ent_data [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_addr = ent_addr[rd_ptr];
    assign head_data = ent_data[rd_ptr];

    // Scan live entries oldest to youngest so the last match wins.
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PW-1:0] k;
            k = PW'((int'(rd_ptr) + i) % DEPTH);
            if (i < int'(count) && ent_addr[k] == look_addr) begin
                look_hit  = 1'b1;
                look_data = ent_data[k];
            end
        end
    end

    // Write the new entry into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[wr_ptr] <= push_addr;
            ent_data[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R4
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/sbl_lock.sv
// Global lock register. Grants an acquire when the lock is free (lowest
// index wins a tie) and accepts a release only from the owner. Assumes the
// requests already include the issuer's empty-buffer condition.
module sbl_lock #(
    parameter int NPROC = 2,
    localparam int OW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] acq_req,
    input  logic [NPROC-1:0] rel_req,
    output logic [NPROC-1:0] acq_ok,
    output logic [NPROC-1:0] rel_ok,
    output logic             held,
    output logic [OW-1:0]    owner
);
    logic [OW-1:0] win_idx;

    // Pick the lowest requesting processor when the lock is free.
    always_comb begin
        acq_ok  = '0;
        win_idx = '0;
        for (int i = 0; i < NPROC; i++) begin
            if (acq_req[i] && !held && acq_ok == '0) begin
                acq_ok[i] = 1'b1;
                win_idx   = OW'(i);
            end
        end
    end

    // Release is valid only from the current owner.
    always_comb begin
        for (int i = 0; i < NPROC; i++)
            rel_ok[i] = rel_req[i] && held && (owner == OW'(i));
    end

    // Update lock ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            owner <= '0;
        end else if (acq_ok != '0) begin
            held  <= 1'b1;
            owner <= win_idx;
        end else if (rel_ok != '0) begin
            held  <= 1'b0;
        end
    end

    // R1
    single_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acq_ok));
    // R1
    acq_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_ok != '0) |=> held);
    // R2
    rel_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ok != '0) |=> !held);
    // R1
    owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && rel_ok == '0) |=> (held && $stable(owner)));
endmodule

// File: rtl/sbl_drain_arb.sv
// Round-robin arbiter for drain requests: at most one grant per cycle,
// starting the search at the favoured processor and moving the favour past
// the winner after each grant. Assumes eligibility is already lock-qualified.
module sbl_drain_arb #(
    parameter int NPROC = 2,
    localparam int OW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] elig,
    output logic [NPROC-1:0] grant,
    output logic             grant_any,
    output logic [OW-1:0]    grant_idx
);
    logic [OW-1:0] rr_ptr;

    // Search from the favoured processor for the first eligible one.
    always_comb begin
        grant     = '0;
        grant_any = 1'b0;
        grant_idx = '0;
        for (int i = 0; i < NPROC; i++) begin
            int c;
            c = (int'(rr_ptr) + i) % NPROC;
            if (!grant_any && elig[c]) begin
                grant[c]  = 1'b1;
                grant_any = 1'b1;
                grant_idx = OW'(c);
            end
        end
    end

    // Move the favour to the processor after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (grant_any)
            rr_ptr <= (grant_idx == OW'(NPROC - 1)) ? '0 : grant_idx + 1'b1;
    end

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8
    favour_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |=> (rr_ptr != $past(grant_idx)));
endmodule

// File: rtl/tso_sbuf_lock.sv
// Top level: per-processor store buffers, global lock, drain arbiter and
// the shared memory. Each processor offers one command per cycle and gets
// a same-cycle accept; reads answer one cycle later. Assumes a stalled
// command is held stable by the issuer until accepted.
module tso_sbuf_lock
    import sbl_pkg::*;
#(
    parameter int NPROC = 2,
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPROC-1:0]     cmd_valid,
    input  logic [NPROC*OPW-1:0] cmd_op,
    input  logic [NPROC*AW-1:0]  cmd_addr,
    input  logic [NPROC*DW-1:0]  cmd_wdata,
    output logic [NPROC-1:0]     cmd_accept,
    output logic [NPROC-1:0]     rd_valid,
    output logic [NPROC*DW-1:0]  rd_data,
    input  logic [NPROC-1:0]     drain_req,
    output logic [NPROC-1:0]     drain_grant
);
    localparam int MEMD = 1 << AW;
    localparam int OW   = (NPROC > 1) ? $clog2(NPROC) : 1;

    logic [DW-1:0]    mem [MEMD];
    logic [NPROC-1:0] buf_empty, buf_full, fwd_hit, elig;
    logic [NPROC-1:0] acq_req, rel_req, acq_ok, rel_ok, rd_take;
    logic [DW-1:0]    fwd_data [NPROC];
    logic [DW-1:0]    rd_next  [NPROC];
    logic [AW-1:0]    hd_addr  [NPROC];
    logic [DW-1:0]    hd_data  [NPROC];
    logic             lock_held, grant_any;
    logic [OW-1:0]    lock_owner, grant_idx;

    for (genvar gp = 0; gp < NPROC; gp++) begin : g_proc
        sbl_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          acc, is_wr;

        assign op    = sbl_op_e'(cmd_op[gp*OPW +: OPW]);
        assign addr  = cmd_addr[gp*AW +: AW];
        assign wdata = cmd_wdata[gp*DW +: DW];
        assign is_wr = cmd_valid[gp] && op == OP_WRITE;

        assign acq_req[gp] = cmd_valid[gp] && op == OP_ACQ && buf_empty[gp];
        assign rel_req[gp] = cmd_valid[gp] && op == OP_REL && buf_empty[gp];
        assign elig[gp]    = drain_req[gp] && !buf_empty[gp] &&
                             (!lock_held || lock_owner == OW'(gp));

        // Decide accept or stall for this processor's command.
        always_comb begin
            case (op)
                OP_WRITE: acc = !buf_full[gp];
                OP_READ:  acc = 1'b1;
                OP_FENCE: acc = buf_empty[gp];
                OP_ACQ:   acc = acq_ok[gp];
                OP_REL:   acc = rel_ok[gp];
                default:  acc = 1'b1;
            endcase
        end
        assign cmd_accept[gp] = cmd_valid[gp] && acc;

        // Read result: own-buffer forward first, memory otherwise.
        assign rd_take[gp] = cmd_valid[gp] && op == OP_READ;
        assign rd_next[gp] = fwd_hit[gp] ? fwd_data[gp] : mem[addr];

        sbl_store_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (is_wr && !buf_full[gp]),
            .push_addr (addr),
            .push_data (wdata),
            .pop       (drain_grant[gp]),
            .look_addr (addr),
            .look_hit  (fwd_hit[gp]),
            .look_data (fwd_data[gp]),
            .head_addr (hd_addr[gp]),
            .head_data (hd_data[gp]),
            .empty     (buf_empty[gp]),
            .full      (buf_full[gp])
        );

        // R5
        drain_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            drain_grant[gp] |-> (!lock_held || lock_owner == OW'(gp)));
        // R3
        fence_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_accept[gp] && op == OP_FENCE) |-> buf_empty[gp]);
        // R6
        read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_accept[gp] && op == OP_READ) |=> rd_valid[gp]);
    end

    sbl_lock #(.NPROC(NPROC)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq_req (acq_req),
        .rel_req (rel_req),
        .acq_ok  (acq_ok),
        .rel_ok  (rel_ok),
        .held    (lock_held),
        .owner   (lock_owner)
    );

    sbl_drain_arb #(.NPROC(NPROC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .grant     (drain_grant),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    // Shared memory: cleared on reset, written by the granted buffer head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMD; i++) mem[i] <= '0;
        end else if (grant_any) begin
            mem[hd_addr[grant_idx]] <= hd_data[grant_idx];
        end
    end

    // Register read responses for every processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
            rd_data  <= '0;
        end else begin
            for (int p = 0; p < NPROC; p++) begin
                rd_valid[p] <= rd_take[p];
                if (rd_take[p]) rd_data[p*DW +: DW] <= rd_next[p];
            end
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_valid == '0 && !lock_held));
endmodule

// File: tb/tso_sbuf_lock_bench.sv
`timescale 1ns/1ps
module tso_sbuf_lock_bench;
    localparam int NP = 2, DP = 4, AW = 8, DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NP-1:0]    cmd_valid = '0;
    logic [NP*3-1:0]  cmd_op    = '0;
    logic [NP*AW-1:0] cmd_addr  = '0;
    logic [NP*DW-1:0] cmd_wdata = '0;
    logic [NP-1:0]    drain_req = '0;
    logic [NP-1:0]    cmd_accept, rd_valid, drain_grant;
    logic [NP*DW-1:0] rd_data;

    tso_sbuf_lock #(.NPROC(NP), .DEPTH(DP), .AW(AW), .DW(DW)) u_tso_sbuf_lock (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_accept(cmd_accept),
        .rd_valid(rd_valid), .rd_data(rd_data), .drain_req(drain_req),
        .drain_grant(drain_grant));

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model
    logic [31:0] mmem [256];
    logic [39:0] mq [2][$];
    logic [31:0] eq [2][$];
    string       etag [2][$];
    string       rtag [2];
    bit          m_held;
    int          m_owner, m_rr;
    bit [1:0]    last_acc;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic string optag(input int op);
        case (op)
            1: return "R4";
            2: return "R6";
            4: return "R1";
            5: return "R2";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [31:0] mread(input int p, input logic [7:0] a);
        for (int i = mq[p].size() - 1; i >= 0; i--)
            if (mq[p][i][39:32] == a) return mq[p][i][31:0];
        return mmem[a];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mmem[i] = '0;
        for (int p = 0; p < 2; p++) begin
            mq[p].delete(); eq[p].delete(); etag[p].delete();
            rtag[p] = "R6";
        end
        m_held = 0; m_owner = 0; m_rr = 0;
    endtask

    // One cycle: check accepts and grants against the model, then advance it.
    task automatic step();
        int op [2];
        bit [1:0] acc, el, eg;
        bit a0;
        #1;
        for (int p = 0; p < 2; p++) op[p] = int'(cmd_op[p*3 +: 3]);
        a0 = cmd_valid[0] && op[0] == 4 && mq[0].size() == 0 && !m_held;
        acc = '0;
        for (int p = 0; p < 2; p++) begin
            if (cmd_valid[p]) begin
                case (op[p])
                    1: acc[p] = mq[p].size() < DP;
                    2: acc[p] = 1'b1;
                    3: acc[p] = mq[p].size() == 0;
                    4: acc[p] = mq[p].size() == 0 && !m_held && (p == 0 || !a0);
                    5: acc[p] = mq[p].size() == 0 && m_held && m_owner == p;
                    default: acc[p] = 1'b1;
                endcase
                chk(cmd_accept[p] == acc[p], optag(op[p]), 64'(cmd_accept[p]), 64'(acc[p]));
            end
            el[p] = drain_req[p] && mq[p].size() > 0 && (!m_held || m_owner == p);
        end
        eg = (el == 2'b11) ? 2'(1 << m_rr) : el;
        if (drain_req != '0) chk(drain_grant == eg, "R5/R8", 64'(drain_grant), 64'(eg));
        for (int p = 0; p < 2; p++)
            if (acc[p] && op[p] == 2) begin
                eq[p].push_back(mread(p, cmd_addr[p*8 +: 8]));
                etag[p].push_back(rtag[p]);
            end
        for (int p = 0; p < 2; p++)
            if (eg[p]) begin
                logic [39:0] e;
                e = mq[p].pop_front();
                mmem[e[39:32]] = e[31:0];
                m_rr = 1 - p;
            end
        for (int p = 0; p < 2; p++)
            if (acc[p]) begin
                if (op[p] == 1) mq[p].push_back({cmd_addr[p*8 +: 8], cmd_wdata[p*32 +: 32]});
                if (op[p] == 4) begin m_held = 1; m_owner = p; end
                if (op[p] == 5) m_held = 0;
            end
        last_acc = acc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input int p, input int op, input int a, input int d);
        cmd_valid[p]         = 1'b1;
        cmd_op[p*3 +: 3]     = op[2:0];
        cmd_addr[p*8 +: 8]   = a[7:0];
        cmd_wdata[p*32 +: 32] = d;
    endtask

    task automatic one(input int p, input int op, input int a, input int d, input string tag);
        issue(p, op, a, d);
        rtag[p] = tag;
        step();
        cmd_valid[p] = 1'b0;
    endtask

    task automatic until_acc(input int p, input int op, input int a, input int d, input string tag, input int maxc);
        issue(p, op, a, d);
        rtag[p] = tag;
        for (int i = 0; i < maxc; i++) begin
            step();
            if (last_acc[p]) break;
        end
        chk(last_acc[p], tag, 64'(last_acc[p]), 64'd1);
        cmd_valid[p] = 1'b0;
    endtask

    // Monitor: compare every read result with the queued expectation.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (rd_valid[p]) begin
                    if (eq[p].size() == 0) begin
                        chk(1'b0, "R6", 64'(rd_valid[p]), 64'd0);
                    end else begin
                        logic [31:0] e;
                        string t;
                        e = eq[p].pop_front();
                        t = etag[p].pop_front();
                        chk(rd_data[p*32 +: 32] == e, t, 64'(rd_data[p*32 +: 32]), 64'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: quiet outputs and empty buffers after reset
        chk(rd_valid == '0 && drain_grant == '0, "R9", 64'(rd_valid), 64'd0);
        one(0, 3, 0, 0, "R9");
        one(1, 4, 0, 0, "R9");
        one(1, 5, 0, 0, "R9");
        one(0, 2, 8'h10, 0, "R9");

        // R6: forwarding from the own buffer only
        one(0, 1, 8'h10, 1, "R4");
        one(0, 1, 8'h10, 2, "R4");
        issue(0, 2, 8'h10, 0); issue(1, 2, 8'h10, 0);
        rtag[0] = "R6"; rtag[1] = "R6";
        step();
        cmd_valid = '0;

        // R4: fill to DEPTH, then stall, also in a draining cycle
        one(0, 1, 8'h11, 3, "R4");
        one(0, 1, 8'h12, 4, "R4");
        one(0, 1, 8'h13, 5, "R4");
        issue(0, 1, 8'h13, 5);
        drain_req = 2'b01;
        step();
        drain_req = '0;
        step();
        cmd_valid[0] = 1'b0;
        one(1, 2, 8'h10, 0, "R7");

        // R3: fence waits until the buffer has drained
        one(0, 3, 0, 0, "R3");
        drain_req = 2'b01;
        until_acc(0, 3, 0, 0, "R3", 20);
        drain_req = '0;
        one(1, 2, 8'h10, 0, "R7");
        one(1, 2, 8'h13, 0, "R7");
        one(0, 0, 0, 0, "R3");
        one(0, 6, 8'h13, 9, "R3");
        one(0, 2, 8'h13, 0, "R3");

        // R7: same-address writes committed in program order
        one(0, 1, 8'h40, 7, "R4");
        one(0, 1, 8'h40, 8, "R4");
        drain_req = 2'b01; step(); drain_req = '0;
        one(1, 2, 8'h40, 0, "R7");
        drain_req = 2'b01; step(); drain_req = '0;
        one(1, 2, 8'h40, 0, "R7");

        // R1/R2/R5: lock exclusion
        one(1, 1, 8'h20, 9, "R4");
        one(1, 4, 0, 0, "R1");
        drain_req = 2'b10; step(); drain_req = '0;
        until_acc(1, 4, 0, 0, "R1", 4);
        one(0, 4, 0, 0, "R1");
        one(0, 1, 8'h30, 32'hA, "R4");
        drain_req = 2'b01; step(); drain_req = '0;
        one(0, 2, 8'h30, 0, "R6");
        one(1, 2, 8'h30, 0, "R5");
        one(0, 5, 0, 0, "R2");
        one(1, 1, 8'h31, 32'hB, "R4");
        drain_req = 2'b11; step(); drain_req = '0;
        one(0, 2, 8'h31, 0, "R5");
        one(1, 5, 0, 0, "R2");
        one(1, 5, 0, 0, "R2");
        drain_req = 2'b11; step(); drain_req = '0;
        one(1, 2, 8'h30, 0, "R5");

        // R1: simultaneous acquire, processor 0 wins
        issue(0, 4, 0, 0); issue(1, 4, 0, 0);
        step();
        cmd_valid = '0;
        one(1, 5, 0, 0, "R2");
        one(0, 5, 0, 0, "R2");

        // R8: round robin with both buffers eligible
        for (int i = 0; i < 3; i++) begin
            issue(0, 1, 8'h50 + i, 100 + i);
            issue(1, 1, 8'h50 + i, 200 + i);
            step();
        end
        cmd_valid = '0;
        drain_req = 2'b11;
        repeat (7) step();
        drain_req = '0;
        for (int i = 0; i < 3; i++) one(0, 2, 8'h50 + i, 0, "R8");

        // R9: reset clears memory and buffers
        one(1, 1, 8'h60, 32'h55, "R4");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        one(1, 2, 8'h60, 0, "R9");
        one(0, 2, 8'h50, 0, "R9");
        one(1, 3, 0, 0, "R9");

        repeat (3) @(negedge clk);
        chk(eq[0].size() == 0 && eq[1].size() == 0, "R6",
            64'(eq[0].size() + eq[1].size()), 64'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule